// File: doc/BRIEF.md
# Two-stage watchdog timer

This block is a bus-programmed supervision counter with two thresholds. Once software sets the run bit, it counts clock ticks from zero. When the count reaches the warning threshold it can raise a level interrupt, so software has a chance to react. When the count reaches the fatal threshold it raises a reset request toward the system reset generator. Software keeps the system alive by writing the restart register, which sends the count back to zero. Clearing the run bit stops the counter.

A cause flag records that a fatal expiry happened. That flag is cleared only by the power-on reset or by an explicit software write. It therefore survives the system reset that the expiry itself provokes, and boot software can read why the system restarted. A parameter chooses between two register layouts. The second layout has no warning interrupt.

Top module: `dual_stage_wdog`

## Requirements
- R1: With ALT_MAP=0 the registers sit at byte offsets restart 0x04, control 0x08, cause 0x0C, warning threshold 0x10 and fatal threshold 0x14. Read data is registered and appears one clock after the read access. The threshold registers read back the value written. Any other offset reads 0, and writes to it change nothing.
- R2: With ALT_MAP=1 the same five registers sit at 0x38, 0x40, 0x44, 0x4C and 0x5C. Control bit 1 is not stored there and reads 0, so irq_o never asserts, while the fatal stage works as in R6.
- R3: Control bit 0 is the run bit. The write that sets it leaves the count at 0, and the count then rises by one on each clock while it is below the fatal threshold. A control write with bit 0 = 0 stops counting and returns the count to 0.
- R4: A write to the restart register with bit 0 = 1 returns the count to 0 on that clock edge, and counting continues from there.
- R5: irq_o is a level that goes high one clock after the count becomes at least the warning threshold, provided control bits 0 and 1 are both set. It falls on the clock edge of a restart or stop write. If the run bit is set by the write at edge E, irq_o is first high after edge E+B+1, where B is the warning threshold.
- R6: When the count reaches the fatal threshold T, the count holds there and rstreq_o is high for exactly RST_PULSE (16) clocks, after edges E+T+1 through E+T+RST_PULSE. The request fires once until a restart or stop write re-arms it. rst_i does not shorten a pulse.
- R7: If the warning and fatal thresholds are equal, irq_o and rstreq_o rise on the same clock.
- R8: Cause bit 0 is set in the same clock that the reset request starts. A write of 1 to cause bit 0 clears it. rst_i does not clear it; only por_i does.
- R9: rst_i or por_i clears the control bits, both thresholds, the count and irq_o. After por_i, every output and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_i | input | 1 | Power-on reset, synchronous, active high; also clears the cause flag |
| rst_i | input | 1 | System reset, synchronous, active high; leaves the cause flag intact |
| bus_sel_i | input | 1 | Register access strobe for one clock |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the clock after a read access |
| irq_o | output | 1 | Warning interrupt, level |
| rstreq_o | output | 1 | Reset request, fixed-length pulse |

## Verification
The warning interrupt and the reset request can start in the same clock when both thresholds hold the same value. The bench programs both thresholds to 8 and samples both outputs one clock after the count reaches 8. At that point both must already be high. One clock earlier, in a neighbouring vector, both must still be low. Vectors with the warning threshold above the fatal one check the other side: the reset request fires and the interrupt never does, because the count stops at the fatal value.

// File: rtl/dual_stage_wdog_pkg.sv
package dual_stage_wdog_pkg;
  localparam int BUS_W = 32;

  typedef enum logic [2:0] {
    RSEL_NONE,
    RSEL_RESTART,
    RSEL_CTRL,
    RSEL_CAUSE,
    RSEL_WARN,
    RSEL_FATAL
  } rsel_e;

  function automatic rsel_e map_primary(input logic [31:0] off);
    case (off)
      32'h04:  return RSEL_RESTART;
      32'h08:  return RSEL_CTRL;
      32'h0C:  return RSEL_CAUSE;
      32'h10:  return RSEL_WARN;
      32'h14:  return RSEL_FATAL;
      default: return RSEL_NONE;
    endcase
  endfunction

  function automatic rsel_e map_alternate(input logic [31:0] off);
    case (off)
      32'h38:  return RSEL_RESTART;
      32'h40:  return RSEL_CTRL;
      32'h44:  return RSEL_CAUSE;
      32'h4C:  return RSEL_WARN;
      32'h5C:  return RSEL_FATAL;
      default: return RSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dsw_decode.sv
module dsw_decode
  import dual_stage_wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output rsel_e             sel_o
);
  logic [31:0] off;
  assign off = 32'(addr_i);

  generate
    if (ALT_MAP) begin : g_alt
      assign sel_o = map_alternate(off);
    end else begin : g_std
      assign sel_o = map_primary(off);
    end
  endgenerate
endmodule

// File: rtl/dsw_regs.sv
module dsw_regs
  import dual_stage_wdog_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 32,
  parameter bit ALT_MAP = 1'b0
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [BUS_W-1:0]  bus_wdata_i,
  input  logic              fire_i,
  output logic              run_o,
  output logic              irq_en_o,
  output logic [CNT_W-1:0]  warn_o,
  output logic [CNT_W-1:0]  fatal_o,
  output logic              cnt_clr_o,
  output logic              cause_o,
  output logic              cause_clr_o,
  output logic [BUS_W-1:0]  rdata_o
);
  rsel_e            sel;
  logic             wr_en, rd_en, soft_rst;
  logic [1:0]       ctl_q;
  logic [CNT_W-1:0] warn_q, fatal_q;
  logic             cause_q;
  logic [BUS_W-1:0] rd_mux;

  dsw_decode #(.ADDR_W(ADDR_W), .ALT_MAP(ALT_MAP)) u_dec (
    .addr_i (bus_addr_i),
    .sel_o  (sel)
  );

  assign wr_en    = bus_sel_i & bus_wr_i;
  assign rd_en    = bus_sel_i & ~bus_wr_i;
  assign soft_rst = rst_i | por_i;

  always_ff @(posedge clk_i) begin
    if (soft_rst) begin
      ctl_q   <= '0;
      warn_q  <= '0;
      fatal_q <= '0;
    end else if (wr_en) begin
      case (sel)
        RSEL_CTRL: begin
          ctl_q[0] <= bus_wdata_i[0];
          ctl_q[1] <= ALT_MAP ? 1'b0 : bus_wdata_i[1];
        end
        RSEL_WARN:  warn_q  <= bus_wdata_i[CNT_W-1:0];
        RSEL_FATAL: fatal_q <= bus_wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  assign cnt_clr_o   = wr_en & (((sel == RSEL_RESTART) & bus_wdata_i[0]) |
                                ((sel == RSEL_CTRL) & ~bus_wdata_i[0]));
  assign cause_clr_o = wr_en & (sel == RSEL_CAUSE) & bus_wdata_i[0];

  // cause flag: power-on reset only, a fatal expiry wins over a clear
  always_ff @(posedge clk_i) begin
    if (por_i)            cause_q <= 1'b0;
    else if (fire_i)      cause_q <= 1'b1;
    else if (cause_clr_o) cause_q <= 1'b0;
  end

  always_comb begin
    case (sel)
      RSEL_CTRL:  rd_mux = {{(BUS_W-2){1'b0}}, ctl_q};
      RSEL_CAUSE: rd_mux = {{(BUS_W-1){1'b0}}, cause_q};
      RSEL_WARN:  rd_mux = BUS_W'(warn_q);
      RSEL_FATAL: rd_mux = BUS_W'(fatal_q);
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (soft_rst) rdata_o <= '0;
    else          rdata_o <= rd_en ? rd_mux : '0;
  end

  assign run_o    = ctl_q[0];
  assign irq_en_o = ctl_q[1];
  assign warn_o   = warn_q;
  assign fatal_o  = fatal_q;
  assign cause_o  = cause_q;
endmodule

// File: rtl/dsw_core.sv
module dsw_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             run_i,
  input  logic             irq_en_i,
  input  logic [CNT_W-1:0] warn_i,
  input  logic [CNT_W-1:0] fatal_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             fire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_n_q;
  logic             at_fatal;

  assign at_fatal = cnt_q >= fatal_i;
  assign fire_o   = run_i & at_fatal & ~armed_n_q & ~clr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i)                     cnt_q <= '0;
    else if (clr_i)                cnt_q <= '0;
    else if (run_i && !at_fatal)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)       armed_n_q <= 1'b0;
    else if (clr_i)  armed_n_q <= 1'b0;
    else if (fire_o) armed_n_q <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) irq_o <= 1'b0;
    else       irq_o <= run_i & irq_en_i & (cnt_q >= warn_i) & ~clr_i;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/dsw_pulse.sv
module dsw_pulse #(
  parameter int LEN = 16
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic fire_i,
  output logic req_o
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    if (fire_i && left_q == '0) left_d = CW'(LEN);
    else if (left_q != '0)      left_d = left_q - 1'b1;
    else                        left_d = left_q;
  end

  always_ff @(posedge clk_i) begin
    if (por_i) begin
      left_q <= '0;
      req_o  <= 1'b0;
    end else begin
      left_q <= left_d;
      req_o  <= left_d != '0;
    end
  end
endmodule

// File: rtl/dual_stage_wdog.sv
module dual_stage_wdog
  import dual_stage_wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 32,
  parameter int RST_PULSE = 16,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic              clk_i,
  input  logic              por_i,
  input  logic              rst_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  output logic              rstreq_o
);
  logic             soft_rst;
  logic             run, irq_en, cnt_clr, cause, cause_clr, fire;
  logic [CNT_W-1:0] warn_thr, fatal_thr, cnt;

  assign soft_rst = rst_i | por_i;

  dsw_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ALT_MAP(ALT_MAP)) u_regs (
    .clk_i       (clk_i),
    .por_i       (por_i),
    .rst_i       (rst_i),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .fire_i      (fire),
    .run_o       (run),
    .irq_en_o    (irq_en),
    .warn_o      (warn_thr),
    .fatal_o     (fatal_thr),
    .cnt_clr_o   (cnt_clr),
    .cause_o     (cause),
    .cause_clr_o (cause_clr),
    .rdata_o     (bus_rdata_o)
  );

  dsw_core #(.CNT_W(CNT_W)) u_core (
    .clk_i    (clk_i),
    .rst_i    (soft_rst),
    .run_i    (run),
    .irq_en_i (irq_en),
    .warn_i   (warn_thr),
    .fatal_i  (fatal_thr),
    .clr_i    (cnt_clr),
    .cnt_o    (cnt),
    .irq_o    (irq_o),
    .fire_o   (fire)
  );

  dsw_pulse #(.LEN(RST_PULSE)) u_pulse (
    .clk_i  (clk_i),
    .por_i  (por_i),
    .fire_i (fire),
    .req_o  (rstreq_o)
  );
endmodule

// File: rtl/dsw_chk.sv
module dsw_chk #(
  parameter int CNT_W     = 32,
  parameter int RST_PULSE = 16,
  parameter bit ALT_MAP   = 1'b0
) (
  input logic             clk_i,
  input logic             por_i,
  input logic             rst_i,
  input logic             irq_o,
  input logic             rstreq_o,
  input logic             run,
  input logic             irq_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] fatal_thr,
  input logic             cnt_clr,
  input logic             cause,
  input logic             cause_clr
);
  logic [31:0] hi_len;

  always_ff @(posedge clk_i) begin
    if (por_i)         hi_len <= '0;
    else if (rstreq_o) hi_len <= hi_len + 1;
    else               hi_len <= '0;
  end

  // R3
  count_step_chk: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    (run && !cnt_clr && cnt < fatal_thr) |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R4
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    cnt_clr |=> cnt == '0);

  // R5
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    irq_o |-> $past(run && irq_en));

  // R6
  pulse_len_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(rstreq_o) |-> hi_len == RST_PULSE);

  // R8
  cause_set_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $rose(rstreq_o) |-> cause);

  // R8
  cause_hold_chk: assert property (@(posedge clk_i) disable iff (por_i)
    $fell(cause) |-> $past(cause_clr));

  // R2
  alt_no_irq_chk: assert property (@(posedge clk_i) disable iff (por_i)
    (ALT_MAP == 1'b0) || !irq_o);
endmodule

bind dual_stage_wdog dsw_chk #(.CNT_W(CNT_W), .RST_PULSE(RST_PULSE), .ALT_MAP(ALT_MAP)) u_chk (
  .clk_i     (clk_i),
  .por_i     (por_i),
  .rst_i     (rst_i),
  .irq_o     (irq_o),
  .rstreq_o  (rstreq_o),
  .run       (run),
  .irq_en    (irq_en),
  .cnt       (cnt),
  .fatal_thr (fatal_thr),
  .cnt_clr   (cnt_clr),
  .cause     (cause),
  .cause_clr (cause_clr)
);

// File: tb/dual_stage_wdog_bench.sv
module dual_stage_wdog_bench;
  localparam logic [7:0] A_RESTART = 8'h04, A_CTRL = 8'h08, A_CAUSE = 8'h0C,
                         A_WARN = 8'h10, A_FATAL = 8'h14;
  localparam logic [7:0] B_CTRL = 8'h40, B_WARN = 8'h4C, B_FATAL = 8'h5C;

  typedef struct packed {
    logic [31:0] warn;
    logic [31:0] fatal;
    logic [1:0]  ctl;
    logic [15:0] wait_n;
    logic        exp_irq;
    logic        exp_req;
  } vec_t;

  // irq expected iff ctl==3 and wait_n >= warn+1 and warn <= fatal;
  // request expected iff fatal+1 <= wait_n <= fatal+16
  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'd5,  32'd20, 2'd3, 16'd5,  1'b0, 1'b0},
    '{32'd5,  32'd20, 2'd3, 16'd6,  1'b1, 1'b0},
    '{32'd5,  32'd20, 2'd1, 16'd10, 1'b0, 1'b0},
    '{32'd5,  32'd20, 2'd3, 16'd21, 1'b1, 1'b1},
    '{32'd5,  32'd20, 2'd3, 16'd36, 1'b1, 1'b1},
    '{32'd5,  32'd20, 2'd3, 16'd37, 1'b1, 1'b0},
    '{32'd8,  32'd8,  2'd3, 16'd9,  1'b1, 1'b1},
    '{32'd8,  32'd8,  2'd3, 16'd8,  1'b0, 1'b0},
    '{32'd30, 32'd10, 2'd3, 16'd15, 1'b0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        por = 1'b1, rst = 1'b1;
  logic        sel = 1'b0, wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_alt;
  logic        irq, req, irq_alt, req_alt;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  dual_stage_wdog u_dual_stage_wdog (
    .clk_i(clk), .por_i(por), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .rstreq_o(req)
  );

  dual_stage_wdog #(.ALT_MAP(1'b1)) u_dual_stage_wdog_alt (
    .clk_i(clk), .por_i(por), .rst_i(rst), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata_alt),
    .irq_o(irq_alt), .rstreq_o(req_alt)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d_alt);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
    d = rdata;
    d_alt = rdata_alt;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [31:0] d, da;
    repeat (3) @(negedge clk);
    por = 1'b0; rst = 1'b0;

    // R9 reset state
    chk("R9 irq after reset", {31'b0, irq}, 32'd0);
    chk("R9 request after reset", {31'b0, req}, 32'd0);
    bus_read(A_CAUSE, d, da);
    chk("R9 cause after reset", d, 32'd0);
    bus_read(A_WARN, d, da);
    chk("R9 warning threshold after reset", d, 32'd0);

    // R1 readback and unmapped offsets
    bus_write(A_WARN, 32'hDEADBEEF);
    bus_read(A_WARN, d, da);
    chk("R1 warning readback", d, 32'hDEADBEEF);
    bus_write(A_FATAL, 32'h1000_0000);
    bus_read(A_FATAL, d, da);
    chk("R1 fatal readback", d, 32'h1000_0000);
    bus_write(8'h18, 32'hFFFF_FFFF);
    bus_read(8'h18, d, da);
    chk("R1 unmapped read", d, 32'd0);

    // R3 R5 R6 R7 vector walk
    for (int i = 0; i < NV; i++) begin
      bus_write(A_CTRL, 32'd0);
      repeat (20) @(negedge clk);
      bus_write(A_WARN, VECS[i].warn);
      bus_write(A_FATAL, VECS[i].fatal);
      bus_write(A_CTRL, {30'b0, VECS[i].ctl});
      repeat (int'(VECS[i].wait_n)) @(negedge clk);
      chk($sformatf("R5 R7 irq vector %0d", i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
      chk($sformatf("R6 R7 request vector %0d", i), {31'b0, req}, {31'b0, VECS[i].exp_req});
    end
    bus_write(A_CTRL, 32'd0);
    repeat (20) @(negedge clk);

    // R4 restart returns the count to zero
    bus_write(A_WARN, 32'd5);
    bus_write(A_FATAL, 32'd100);
    bus_write(A_CTRL, 32'd3);
    repeat (3) @(negedge clk);
    bus_write(A_RESTART, 32'd1);
    repeat (5) @(negedge clk);
    chk("R4 count restarted, irq still low", {31'b0, irq}, 32'd0);
    @(negedge clk);
    chk("R4 irq after warning from restart", {31'b0, irq}, 32'd1);
    bus_write(A_CTRL, 32'd0);
    chk("R3 R5 stop clears irq", {31'b0, irq}, 32'd0);

    // R8 cause flag
    bus_write(A_CAUSE, 32'd1);
    bus_read(A_CAUSE, d, da);
    chk("R8 cause cleared by write", d, 32'd0);
    bus_write(A_WARN, 32'd100);
    bus_write(A_FATAL, 32'd4);
    bus_write(A_CTRL, 32'd1);
    repeat (6) @(negedge clk);
    chk("R6 request at fatal", {31'b0, req}, 32'd1);
    bus_read(A_CAUSE, d, da);
    chk("R8 cause set by expiry", d, 32'd1);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    bus_read(A_CAUSE, d, da);
    chk("R8 cause survives system reset", d, 32'd1);
    bus_read(A_CTRL, d, da);
    chk("R9 control cleared by system reset", d, 32'd0);
    repeat (20) @(negedge clk);

    // R2 alternate layout
    bus_write(B_WARN, 32'd3);
    bus_write(B_FATAL, 32'd50);
    bus_write(B_CTRL, 32'd3);
    repeat (10) @(negedge clk);
    chk("R2 no irq in alternate layout", {31'b0, irq_alt}, 32'd0);
    bus_read(B_CTRL, d, da);
    chk("R2 control bit 1 not kept", da, 32'd1);
    chk("R1 alternate offset unmapped in primary", d, 32'd0);
    bus_read(B_WARN, d, da);
    chk("R2 alternate warning readback", da, 32'd3);
    repeat (40) @(negedge clk);
    chk("R2 alternate fatal request", {31'b0, req_alt}, 32'd1);
    chk("R1 primary idle during alternate writes", {31'b0, req}, 32'd0);

    done = 1'b1;
    summary();
  end
endmodule